// File: doc/BRIEF.md
# Transmit Packet Priority Multiplexer

This block merges several packet producers onto one streaming transmit port. Five producers feed it: a register block that returns completions, a DMA write engine, a DMA read engine and two descriptor fetch engines. Every producer offers whole packets as a run of beats, each beat one dword wide. A packet is a 3- or 4-dword header, then at most one alignment dword, then any number of payload dwords. Start and end flags mark the first and last beats.

While the multiplexer is idle, it picks one producer by fixed rank from those that present a start beat. It then holds that choice until the end beat has been taken by the port. The completion producer has the top rank, so a completion can pass requests that are waiting. The port's ready signal goes straight to the owning producer and to no other producer, so backpressure holds the current beat and does not reorder anything. A producer raises a start beat only when its whole packet is already buffered. Because of this, a granted packet goes out with no gaps.

The forward path is combinational. A start beat that the port accepts goes out in the same cycle it is presented. A new packet may begin in the cycle after the previous end beat.

Top module: `tx_prio_mux`

## Requirements
- R1: After reset, with no producer valid, `tx_valid` is low and every bit of `src_ready` is low.
- R2: When idle, the lowest-indexed producer that presents a start beat wins. Index 0 is the completion producer, and it ranks above every request producer.
- R3: Among request producers the rank is index 1 (DMA write), then 2 (DMA read), then 3 and 4 (descriptor fetchers, 3 first).
- R4: A producer owns the port from the first cycle its start beat is presented until its end beat is accepted. Any other producer waits for that time, including a higher-ranked one and including while `tx_ready` is low before the first beat is taken.
- R5: Beats reach the port unchanged and in order. `tx_data`, `tx_sop` and `tx_eop` equal the owner's `src_data` slice (bits `i*DATA_W` upward for producer i), `src_sop[i]` and `src_eop[i]`.
- R6: While `tx_ready` is low, every `src_ready` bit is low, and a presented beat stays on the port unchanged until it is accepted.
- R7: At most one `src_ready` bit is high, and it belongs to the current owner.
- R8: When idle, a producer whose valid beat lacks the start flag is not granted: `tx_valid` stays low and its `src_ready` stays low.
- R9: A new packet can start in the cycle after an end beat is accepted. With producers and port both continuous, N queued beats leave in N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | NUM_SRC | Producer beat valid, one bit per producer |
| src_sop | input | NUM_SRC | Producer beat is first of its packet |
| src_eop | input | NUM_SRC | Producer beat is last of its packet |
| src_data | input | NUM_SRC*DATA_W | Producer beat data, producer i at bits i*DATA_W upward |
| src_ready | output | NUM_SRC | Beat taken from producer this cycle |
| tx_valid | output | 1 | Port beat valid |
| tx_sop | output | 1 | Port beat is first of a packet |
| tx_eop | output | 1 | Port beat is last of a packet |
| tx_data | output | DATA_W | Port beat data |
| tx_ready | input | 1 | Port accepts the beat |

## Verification
The assertions assume the producers behave well. A producer keeps its beat stable until `src_ready` takes it. It raises a start beat only with the whole packet buffered, so it never drops valid in the middle of a packet. The no-gap check and the hold check both depend on these two points. The bench producers are queues that load whole packets in one step and pop a beat only on the cycle it is accepted. This keeps every stimulus inside those assumptions. The single deliberate exception is a lone beat without a start flag, which is presented while the block is idle and is then removed before any packet follows.

// File: rtl/tx_prio_mux_pkg.sv
// Package: shared constants for the transmit packet priority multiplexer.
// Assumes producer index equals rank; index 0 is served first.
package tx_prio_mux_pkg;

    // Roles of the default five producers, in rank order.
    typedef enum int unsigned {
        SRC_CPL    = 0,
        SRC_DMA_WR = 1,
        SRC_DMA_RD = 2,
        SRC_DESC_A = 3,
        SRC_DESC_B = 4
    } src_role_e;

    localparam int DEF_NUM_SRC = 5;
    localparam int DEF_DATA_W  = 32;

endpackage

// File: rtl/txm_prio_pick.sv
// Fixed-rank picker: grants the lowest-indexed requester.
// Assumes NUM_SRC >= 2. Purely combinational.
module txm_prio_pick #(
    parameter int NUM_SRC = tx_prio_mux_pkg::DEF_NUM_SRC,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [NUM_SRC-1:0] gnt_oh,
    output logic [IDX_W-1:0]   gnt_idx,
    output logic               any_req
);

    logic [NUM_SRC:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
        // Each stage is blocked by any requester of better rank.
        assign blocked[g+1] = blocked[g] | req[g];
        assign gnt_oh[g]    = req[g] & ~blocked[g];
    end

    assign any_req = blocked[NUM_SRC];

    // Encode the one-hot grant into an index.
    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (gnt_oh[i]) gnt_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/txm_pkt_lock.sv
// Packet lock: freezes the chosen producer from the first presentation
// of its start beat until its end beat is accepted by the port.
// Assumes owners never drop valid mid-packet.
module txm_pkt_lock #(
    parameter int NUM_SRC = tx_prio_mux_pkg::DEF_NUM_SRC,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_req,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             beat_take,
    input  logic             beat_eop,
    output logic [IDX_W-1:0] sel_idx,
    output logic             sel_vld
);

    logic             busy_q;
    logic [IDX_W-1:0] owner_q;
    logic             pkt_done;

    assign pkt_done = beat_take & beat_eop;

    // Track ownership between packet boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            owner_q <= '0;
        end else if (!busy_q) begin
            if (any_req) begin
                owner_q <= pick_idx;
                busy_q  <= !pkt_done;
            end
        end else if (pkt_done) begin
            busy_q <= 1'b0;
        end
    end

    // Owner while locked, fresh pick while idle.
    always_comb begin
        sel_idx = busy_q ? owner_q : pick_idx;
        sel_vld = busy_q | any_req;
    end

endmodule

// File: rtl/txm_beat_route.sv
// Beat router: steers the selected producer's beat to the port and
// returns the port's ready to that producer only.
// Assumes sel_idx < NUM_SRC whenever sel_vld is high.
module txm_beat_route #(
    parameter int NUM_SRC = tx_prio_mux_pkg::DEF_NUM_SRC,
    parameter int DATA_W  = tx_prio_mux_pkg::DEF_DATA_W,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        src_valid,
    input  logic [NUM_SRC-1:0]        src_sop,
    input  logic [NUM_SRC-1:0]        src_eop,
    input  logic [NUM_SRC*DATA_W-1:0] src_data,
    output logic [NUM_SRC-1:0]        src_ready,
    input  logic [IDX_W-1:0]          sel_idx,
    input  logic                      sel_vld,
    input  logic                      tx_ready,
    output logic                      tx_valid,
    output logic                      tx_sop,
    output logic                      tx_eop,
    output logic [DATA_W-1:0]         tx_data
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rdy
        // Ready reaches only the selected producer.
        assign src_ready[g] = sel_vld && (sel_idx == IDX_W'(g)) && tx_ready;
    end

    // Forward the selected beat.
    always_comb begin
        tx_valid = sel_vld && src_valid[sel_idx];
        tx_sop   = src_sop[sel_idx];
        tx_eop   = src_eop[sel_idx];
        tx_data  = src_data[sel_idx*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/tx_prio_mux.sv
// Transmit packet priority multiplexer top.
// Picks a producer by fixed rank at packet boundaries, locks it for
// the whole packet and streams its beats with ready passed through.
// Assumes producers present a start beat only with the full packet held.
module tx_prio_mux #(
    parameter int NUM_SRC = tx_prio_mux_pkg::DEF_NUM_SRC,
    parameter int DATA_W  = tx_prio_mux_pkg::DEF_DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_valid,
    input  logic [NUM_SRC-1:0]        src_sop,
    input  logic [NUM_SRC-1:0]        src_eop,
    input  logic [NUM_SRC*DATA_W-1:0] src_data,
    output logic [NUM_SRC-1:0]        src_ready,
    output logic                      tx_valid,
    output logic                      tx_sop,
    output logic                      tx_eop,
    output logic [DATA_W-1:0]         tx_data,
    input  logic                      tx_ready
);

    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] gnt_oh;
    logic [IDX_W-1:0]   pick_idx;
    logic               any_req;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_vld;

    // A producer requests only with a start beat on offer.
    assign req = src_valid & src_sop;

    txm_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req     (req),
        .gnt_oh  (gnt_oh),
        .gnt_idx (pick_idx),
        .any_req (any_req)
    );

    txm_pkt_lock #(.NUM_SRC(NUM_SRC)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_req   (any_req && (gnt_oh != '0)),
        .pick_idx  (pick_idx),
        .beat_take (tx_valid && tx_ready),
        .beat_eop  (tx_eop),
        .sel_idx   (sel_idx),
        .sel_vld   (sel_vld)
    );

    txm_beat_route #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_route (
        .src_valid (src_valid),
        .src_sop   (src_sop),
        .src_eop   (src_eop),
        .src_data  (src_data),
        .src_ready (src_ready),
        .sel_idx   (sel_idx),
        .sel_vld   (sel_vld),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_sop    (tx_sop),
        .tx_eop    (tx_eop),
        .tx_data   (tx_data)
    );

endmodule

// File: rtl/tx_prio_mux_chk.sv
// Checker for tx_prio_mux: observes ports only.
// Assumes well-behaved producers (stable beats, no mid-packet drop).
module tx_prio_mux_chk #(
    parameter int NUM_SRC = 5,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SRC-1:0]        src_valid,
    input logic [NUM_SRC*DATA_W-1:0] src_data,
    input logic [NUM_SRC-1:0]        src_ready,
    input logic                      tx_valid,
    input logic                      tx_sop,
    input logic                      tx_eop,
    input logic [DATA_W-1:0]         tx_data,
    input logic                      tx_ready
);

    logic             in_pkt_q;
    logic [IDX_W-1:0] own_q;
    logic [IDX_W-1:0] rdy_idx;

    // Index of the producer being served this cycle.
    always_comb begin
        rdy_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_ready[i]) rdy_idx = IDX_W'(i);
        end
    end

    // Follow packet boundaries as seen on the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt_q <= 1'b0;
            own_q    <= '0;
        end else if (tx_valid && tx_ready) begin
            in_pkt_q <= !tx_eop;
            if (tx_sop) own_q <= rdy_idx;
        end
    end

    assert_single_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready));

    assert_ready_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |-> (src_ready == '0));

    assert_hold_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

    assert_start_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !in_pkt_q |-> tx_sop);

    assert_owner_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_pkt_q && tx_ready |-> src_ready[own_q]);

    assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !tx_eop |=> tx_valid);

    assert_route_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |-> src_valid[rdy_idx] && (tx_data == src_data[rdy_idx*DATA_W +: DATA_W]));

endmodule

bind tx_prio_mux tx_prio_mux_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_ready (src_ready),
    .tx_valid  (tx_valid),
    .tx_sop    (tx_sop),
    .tx_eop    (tx_eop),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
);

// File: tb/test_tx_prio_mux.sv
`timescale 1ns/1ps
// Scoreboard bench: queue-based producers, expected beats in order.
module test_tx_prio_mux;

    localparam int NS = 5;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NS-1:0]     src_valid, src_sop, src_eop, src_ready;
    logic [NS*DW-1:0]  src_data;
    logic              tx_valid, tx_sop, tx_eop, tx_ready;
    logic [DW-1:0]     tx_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit bp    = 1'b0;
    bit rdy_base = 1'b1;
    bit prev_hold = 1'b0;
    logic [33:0] prev_out;
    logic [33:0] srcq [NS][$];
    logic [36:0] expq [$];

    always #2.5 clk = ~clk;

    tx_prio_mux #(.NUM_SRC(NS), .DATA_W(DW)) i_tx_prio_mux (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_sop(src_sop), .src_eop(src_eop),
        .src_data(src_data), .src_ready(src_ready),
        .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int s, input int tag, input int b);
        return {8'(s), 8'(tag), 16'(b)};
    endfunction

    task automatic drive();
        for (int i = 0; i < NS; i++) begin
            if (srcq[i].size() > 0) begin
                src_valid[i] = 1'b1;
                src_sop[i]   = srcq[i][0][33];
                src_eop[i]   = srcq[i][0][32];
                src_data[i*DW +: DW] = srcq[i][0][31:0];
            end else begin
                src_valid[i] = 1'b0;
                src_sop[i]   = 1'b0;
                src_eop[i]   = 1'b0;
                src_data[i*DW +: DW] = '0;
            end
        end
        tx_ready = rdy_base && !(bp && (cyc % 3 == 1));
    endtask

    task automatic load(input int s, input int tag, input int len);
        for (int b = 0; b < len; b++)
            srcq[s].push_back({b == 0, b == len - 1, mk(s, tag, b)});
    endtask

    task automatic expect_pkt(input int s, input int tag, input int len);
        for (int b = 0; b < len; b++)
            expq.push_back({3'(s), b == 0, b == len - 1, mk(s, tag, b)});
    endtask

    // One cycle: compare at negedge, advance producers after posedge.
    task automatic step();
        logic [NS-1:0] acc;
        logic [36:0]   e;
        @(negedge clk);
        cyc++;
        acc = src_valid & src_ready;
        if (prev_hold)
            chk(tx_valid && ({tx_sop, tx_eop, tx_data} == prev_out), "R6", "held beat changed",
                {tx_sop, tx_eop, tx_data}, prev_out);
        prev_hold = tx_valid && !tx_ready;
        prev_out  = {tx_sop, tx_eop, tx_data};
        if (!tx_ready)
            chk(src_ready == '0, "R6", "ready leaked under stall", src_ready, 0);
        if (tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R5", "unexpected beat", tx_data, 0);
            end else begin
                e = expq.pop_front();
                chk(src_ready == (NS'(1) << e[36:34]), "R7", "ready owner", src_ready, NS'(1) << e[36:34]);
                chk({tx_sop, tx_eop, tx_data} == e[33:0], "R5", "beat content",
                    {tx_sop, tx_eop, tx_data}, e[33:0]);
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < NS; i++)
            if (acc[i] && srcq[i].size() > 0) void'(srcq[i].pop_front());
        drive();
    endtask

    task automatic drain(input int max, output int n);
        n = 0;
        while (expq.size() > 0 && n < max) begin
            step();
            n++;
        end
        if (expq.size() > 0) begin
            chk(1'b0, "R5", "watchdog expired with beats pending", expq.size(), 0);
            expq.delete();
            for (int i = 0; i < NS; i++) srcq[i].delete();
            drive();
        end
    endtask

    initial begin
        int n;
        rst_n = 1'b0;
        drive();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
        chk(src_ready == '0, "R1", "src_ready after reset", src_ready, 0);
        @(posedge clk); #1;

        // R2 R3 R9: all producers at once, continuous port.
        load(4, 1, 3); load(3, 1, 4); load(2, 1, 5); load(1, 1, 3); load(0, 1, 4);
        expect_pkt(0, 1, 4); expect_pkt(1, 1, 3); expect_pkt(2, 1, 5);
        expect_pkt(3, 1, 4); expect_pkt(4, 1, 3);
        drive();
        drain(200, n);
        chk(n == 19, "R9", "cycles for 19 beats", n, 19);

        // R4: higher rank arrives mid-packet and waits.
        load(4, 2, 6); expect_pkt(4, 2, 6); drive();
        step(); step();
        load(0, 2, 3); expect_pkt(0, 2, 3); drive();
        drain(200, n);

        // R4: lock taken before first beat is accepted.
        rdy_base = 1'b0;
        load(3, 3, 4); expect_pkt(3, 3, 4); drive();
        step(); step();
        load(1, 3, 3); expect_pkt(1, 3, 3); drive();
        step();
        #1;
        chk(tx_valid && tx_data == mk(3, 3, 0), "R4", "stalled owner still presented", tx_data, mk(3, 3, 0));
        rdy_base = 1'b1; drive();
        drain(200, n);

        // R6 R2 R3: periodic stalls with several producers.
        bp = 1'b1;
        load(2, 4, 5); load(1, 4, 4); load(0, 4, 3); load(3, 4, 4);
        expect_pkt(0, 4, 3); expect_pkt(1, 4, 4); expect_pkt(2, 4, 5); expect_pkt(3, 4, 4);
        drive();
        drain(400, n);
        bp = 1'b0; drive();

        // R8: a valid beat without start flag is not granted.
        srcq[2].push_back({1'b0, 1'b0, mk(2, 9, 1)}); drive();
        for (int k = 0; k < 3; k++) begin
            step();
            #1;
            chk(tx_valid == 1'b0, "R8", "tx_valid for headless beat", tx_valid, 0);
            chk(src_ready[2] == 1'b0, "R8", "ready for headless beat", src_ready[2], 0);
        end
        srcq[2].delete(); drive();

        // R9 R3: same producer queues two packets back to back.
        load(1, 5, 3); load(1, 6, 4); load(2, 5, 3);
        expect_pkt(1, 5, 3); expect_pkt(1, 6, 4); expect_pkt(2, 5, 3);
        drive();
        drain(200, n);
        chk(n == 10, "R9", "back-to-back cycles", n, 10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule